// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Output Latency

This block is a true dual-port static RAM. Two independent ports, each with its own clock and reset, can read or write any word, including the same word in the same cycle. Every port captures its address source, write data and controls in input registers on the rising clock edge. A memory access is performed one edge after that capture. The word width is a parameter (default 9 bits). The depth is 2^ADDR_W words: the default elaborates 2K words, and ADDR_W = 14 gives the 16K-word configuration.

The address of each port comes from a per-port address counter. An access can take an external address, continue from the previous one, repeat it, or start again from zero. A port is selected only while its active-low enable is low and its active-high enable is high. A sampled read/write bit then picks a read (1) or a write (0).

Read data leaves on a data bus paired with a drive-enable flag, which stands in for a tri-state pin. Whether the flag may rise in a cycle depends on the controls registered one cycle earlier. An output-enable input gates the flag at once. A static mode pin, sampled only while reset is held, sets each port separately to flow-through or pipelined output. Pipelined output adds one register stage to the read path.

Each port holds an output-stage state machine with three states: `OS_OFF` (deselected or idle), `OS_READ` (read data in the output register) and `OS_WRITE` (write cycle, output off). On every edge the machine takes the transition named by the registered operation: to `OS_READ` on a registered read, to `OS_WRITE` on a registered write, and to `OS_OFF` otherwise. Reset forces `OS_OFF`. In pipelined mode a copy of this state, delayed by one cycle, travels with the extra data register and decides the drive.

Top module: `twin_port_ram`

## Requirements
- R1: A port with `ceN_x_n`=0, `ce_x`=1 and `rw_x`=0 at an edge writes `din_x` (as registered at that edge) to the access address of that edge. A later selected read (`rw_x`=1) of that address returns the value.
- R2: If `ceN_x_n`=1 or `ce_x`=0 at an edge, that edge starts no write and no read. Memory keeps its contents, and the matching output cycle has `den_x`=0.
- R3: With `pipe_x`=0 held during reset (flow-through), a read sampled at edge N gives `den_x`=1 (when `oe_x_n`=0) and the read word on `dout_x` from edge N+1 until edge N+2.
- R4: With `pipe_x`=1 held during reset (pipelined), a read sampled at edge N is driven from edge N+2 until edge N+3.
- R5: `den_x` is 0 in the output cycle that belongs to a sampled write or deselect, and it is 0 after reset.
- R6: `oe_x_n`=1 forces `den_x` to 0 in the same cycle without waiting for a clock edge. Returning `oe_x_n` to 0 lets pending read data drive again.
- R7: At each edge the access address becomes one of the following, in priority order:
  - 0 if `zero_x_n`=0;
  - otherwise `adr_x` if `load_x_n`=0;
  - otherwise the previous address plus 1, wrapping from 2^ADDR_W-1 to 0, if `step_x_n`=0;
  - otherwise the previous address.

  The chip enables do not affect this. Reset sets the address to 0.
- R8: `pipe_x` is sampled only while `rst_x_n`=0. Changes made after reset is released have no effect until the next reset.
- R9: Both ports may access memory at the same edge. When port A writes a word and port B reads the same word at the same edge of a shared clock, B returns the old word. The new word is visible to either port afterwards.
- R10: `dout_x` is all zeros whenever `den_x` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| pipe_a | input | 1 | Port A output mode: 1 pipelined, 0 flow-through (sampled in reset) |
| ceN_a_n | input | 1 | Port A enable, active low |
| ce_a | input | 1 | Port A enable, active high |
| rw_a | input | 1 | Port A operation: 1 read, 0 write |
| oe_a_n | input | 1 | Port A output enable, active low, asynchronous |
| load_a_n | input | 1 | Port A load external address, active low |
| step_a_n | input | 1 | Port A address increment, active low |
| zero_a_n | input | 1 | Port A address clear, active low |
| adr_a | input | ADDR_W | Port A external address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data (zero when not driven) |
| den_a | output | 1 | Port A drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| pipe_b | input | 1 | Port B output mode |
| ceN_b_n | input | 1 | Port B enable, active low |
| ce_b | input | 1 | Port B enable, active high |
| rw_b | input | 1 | Port B operation |
| oe_b_n | input | 1 | Port B output enable, active low |
| load_b_n | input | 1 | Port B load external address |
| step_b_n | input | 1 | Port B address increment |
| zero_b_n | input | 1 | Port B address clear |
| adr_b | input | ADDR_W | Port B external address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data |
| den_b | output | 1 | Port B drive enable |

## Verification
The hardest case to reach from the ports is a write on one port and a read of the same word on the other port at one shared edge. It needs both ports on a common clock and a reference model that takes both reads before applying either write. The bench drives one clock into both ports and builds every expected value in that order.

A second hard case is the mode pin. It can only change latency through a reset, so the bench runs one reset with A flow-through and B pipelined and a second reset with the modes swapped. Between the two resets it toggles the mode pins to show that latency does not change. Counter priority and wrap-around are reached by pairing clear with load, by stepping while deselected, and by loading the top address.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int NPORT = 2;

    // operation captured in the input register of a port
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // output-stage state of a port
    typedef enum logic [1:0] {
        OS_OFF   = 2'd0,
        OS_READ  = 2'd1,
        OS_WRITE = 2'd2
    } ostate_e;

endpackage

// File: rtl/tpr_addr_ctr.sv
module tpr_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] adr_in,
    output logic [ADDR_W-1:0] adr_q
);

    logic [ADDR_W-1:0] adr_nxt;

    // clear beats load, load beats increment; enables play no part
    always_comb begin
        if (!zero_n) begin
            adr_nxt = '0;
        end else if (!load_n) begin
            adr_nxt = adr_in;
        end else if (!step_n) begin
            adr_nxt = adr_q + 1'b1;
        end else begin
            adr_nxt = adr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
        end else begin
            adr_q <= adr_nxt;
        end
    end

    // R7 checks
    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |=> (adr_q == '0));
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && !load_n) |=> (adr_q == $past(adr_in)));
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && !step_n) |=> (adr_q == ADDR_W'($past(adr_q) + 1'b1)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && step_n) |=> $stable(adr_q));

endmodule

// File: rtl/tpr_xor_core.sv
module tpr_xor_core #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] adr_a,
    input  logic [DATA_W-1:0] wdat_a,
    output logic [DATA_W-1:0] rdat_a,
    input  logic              clk_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] adr_b,
    input  logic [DATA_W-1:0] wdat_b,
    output logic [DATA_W-1:0] rdat_b
);

    localparam int DEPTH = 1 << ADDR_W;

    // one bank per writer; a word is the XOR of both banks
    logic [DATA_W-1:0] bank_a [DEPTH];
    logic [DATA_W-1:0] bank_b [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            bank_a[i] = '0;
            bank_b[i] = '0;
        end
    end

    always_ff @(posedge clk_a) begin
        if (we_a) begin
            bank_a[adr_a] <= wdat_a ^ bank_b[adr_a];
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_b) begin
            bank_b[adr_b] <= wdat_b ^ bank_a[adr_b];
        end
    end

    assign rdat_a = bank_a[adr_a] ^ bank_b[adr_a];
    assign rdat_b = bank_a[adr_b] ^ bank_b[adr_b];

endmodule

// File: rtl/tpr_port.sv
module tpr_port
    import tpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic              ceN_n,
    input  logic              ce,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              zero_n,
    input  logic [ADDR_W-1:0] adr_in,
    input  logic [DATA_W-1:0] din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_adr,
    output logic [DATA_W-1:0] mem_wdat,
    input  logic [DATA_W-1:0] mem_rdat,
    output logic [DATA_W-1:0] dout,
    output logic              den
);

    logic              sel_now;
    logic              rd_req;
    op_e               op_nxt;
    op_e               op_q;
    logic [DATA_W-1:0] din_q;
    logic [ADDR_W-1:0] adr_q;
    logic              mode_q;
    ostate_e           os_q;
    ostate_e           os_nxt;
    ostate_e           pipe_os_q;
    ostate_e           out_os;
    logic [DATA_W-1:0] flow_q;
    logic [DATA_W-1:0] pipe_q;
    logic [DATA_W-1:0] out_dat;
    logic [1:0]        live_q;

    // ---------------- input registers ----------------
    tpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .zero_n (zero_n),
        .load_n (load_n),
        .step_n (step_n),
        .adr_in (adr_in),
        .adr_q  (adr_q)
    );

    assign sel_now = !ceN_n && ce;
    assign rd_req  = sel_now && rw;

    always_comb begin
        if (!sel_now) begin
            op_nxt = OP_NONE;
        end else if (rw) begin
            op_nxt = OP_READ;
        end else begin
            op_nxt = OP_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            din_q  <= '0;
            live_q <= '0;
        end else begin
            op_q   <= op_nxt;
            din_q  <= din;
            live_q <= (live_q == 2'd3) ? live_q : live_q + 2'd1;
        end
    end

    assign mem_we   = (op_q == OP_WRITE);
    assign mem_adr  = adr_q;
    assign mem_wdat = din_q;

    // ---------------- output-stage state machine ----------------
    always_comb begin
        unique case (op_q)
            OP_READ:  os_nxt = OS_READ;
            OP_WRITE: os_nxt = OS_WRITE;
            default:  os_nxt = OS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_q      <= OS_OFF;
            pipe_os_q <= OS_OFF;
            mode_q    <= pipe_sel;
        end else begin
            os_q      <= os_nxt;
            pipe_os_q <= os_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flow_q <= '0;
            pipe_q <= '0;
        end else begin
            if (op_q == OP_READ) begin
                flow_q <= mem_rdat;
            end
            pipe_q <= flow_q;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_os  = mode_q ? pipe_os_q : os_q;
        out_dat = mode_q ? pipe_q : flow_q;
        unique case (out_os)
            OS_READ:  den = !oe_n;
            OS_WRITE: den = 1'b0;
            default:  den = 1'b0;
        endcase
        dout = den ? out_dat : '0;
    end

    // ---------------- assertions ----------------
    a_r3_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && !mode_q && $past(rd_req, 2) && !oe_n) |-> den);
    a_r4_pipe_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && mode_q && $past(rd_req, 3) && !oe_n) |-> den);
    a_r5_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && !mode_q && !$past(rd_req, 2)) |-> !den);
    a_r5_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && mode_q && !$past(rd_req, 3)) |-> !den);
    a_r8_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0) |-> $stable(mode_q));

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
    import tpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              pipe_a,
    input  logic              ceN_a_n,
    input  logic              ce_a,
    input  logic              rw_a,
    input  logic              oe_a_n,
    input  logic              load_a_n,
    input  logic              step_a_n,
    input  logic              zero_a_n,
    input  logic [ADDR_W-1:0] adr_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    output logic              den_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              pipe_b,
    input  logic              ceN_b_n,
    input  logic              ce_b,
    input  logic              rw_b,
    input  logic              oe_b_n,
    input  logic              load_b_n,
    input  logic              step_b_n,
    input  logic              zero_b_n,
    input  logic [ADDR_W-1:0] adr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              den_b
);

    logic              clk_v    [NPORT];
    logic              rst_v    [NPORT];
    logic              pipe_v   [NPORT];
    logic              ceN_v    [NPORT];
    logic              ce_v     [NPORT];
    logic              rw_v     [NPORT];
    logic              oe_v     [NPORT];
    logic              load_v   [NPORT];
    logic              step_v   [NPORT];
    logic              zero_v   [NPORT];
    logic [ADDR_W-1:0] adr_v    [NPORT];
    logic [DATA_W-1:0] din_v    [NPORT];
    logic [DATA_W-1:0] dout_v   [NPORT];
    logic              den_v    [NPORT];
    logic              we_v     [NPORT];
    logic [ADDR_W-1:0] madr_v   [NPORT];
    logic [DATA_W-1:0] mwdat_v  [NPORT];
    logic [DATA_W-1:0] mrdat_v  [NPORT];

    assign clk_v[0]  = clk_a;    assign clk_v[1]  = clk_b;
    assign rst_v[0]  = rst_a_n;  assign rst_v[1]  = rst_b_n;
    assign pipe_v[0] = pipe_a;   assign pipe_v[1] = pipe_b;
    assign ceN_v[0]  = ceN_a_n;  assign ceN_v[1]  = ceN_b_n;
    assign ce_v[0]   = ce_a;     assign ce_v[1]   = ce_b;
    assign rw_v[0]   = rw_a;     assign rw_v[1]   = rw_b;
    assign oe_v[0]   = oe_a_n;   assign oe_v[1]   = oe_b_n;
    assign load_v[0] = load_a_n; assign load_v[1] = load_b_n;
    assign step_v[0] = step_a_n; assign step_v[1] = step_b_n;
    assign zero_v[0] = zero_a_n; assign zero_v[1] = zero_b_n;
    assign adr_v[0]  = adr_a;    assign adr_v[1]  = adr_b;
    assign din_v[0]  = din_a;    assign din_v[1]  = din_b;

    assign dout_a = dout_v[0];
    assign den_a  = den_v[0];
    assign dout_b = dout_v[1];
    assign den_b  = den_v[1];

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        tpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk      (clk_v[g]),
            .rst_n    (rst_v[g]),
            .pipe_sel (pipe_v[g]),
            .ceN_n    (ceN_v[g]),
            .ce       (ce_v[g]),
            .rw       (rw_v[g]),
            .oe_n     (oe_v[g]),
            .load_n   (load_v[g]),
            .step_n   (step_v[g]),
            .zero_n   (zero_v[g]),
            .adr_in   (adr_v[g]),
            .din      (din_v[g]),
            .mem_we   (we_v[g]),
            .mem_adr  (madr_v[g]),
            .mem_wdat (mwdat_v[g]),
            .mem_rdat (mrdat_v[g]),
            .dout     (dout_v[g]),
            .den      (den_v[g])
        );
    end

    tpr_xor_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk_a  (clk_v[0]),
        .we_a   (we_v[0]),
        .adr_a  (madr_v[0]),
        .wdat_a (mwdat_v[0]),
        .rdat_a (mrdat_v[0]),
        .clk_b  (clk_v[1]),
        .we_b   (we_v[1]),
        .adr_b  (madr_v[1]),
        .wdat_b (mwdat_v[1]),
        .rdat_b (mrdat_v[1])
    );

endmodule

// File: tb/twin_port_ram_tb_top.sv
module twin_port_ram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 9;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst_n;
    logic          pipe_a, ceN_a_n, ce_a, rw_a, oe_a_n, load_a_n, step_a_n, zero_a_n;
    logic [AW-1:0] adr_a;
    logic [DW-1:0] din_a;
    logic [DW-1:0] dout_a;
    logic          den_a;
    logic          pipe_b, ceN_b_n, ce_b, rw_b, oe_b_n, load_b_n, step_b_n, zero_b_n;
    logic [AW-1:0] adr_b;
    logic [DW-1:0] din_b;
    logic [DW-1:0] dout_b;
    logic          den_b;

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_a(clk), .rst_a_n(rst_n), .pipe_a(pipe_a), .ceN_a_n(ceN_a_n), .ce_a(ce_a),
        .rw_a(rw_a), .oe_a_n(oe_a_n), .load_a_n(load_a_n), .step_a_n(step_a_n),
        .zero_a_n(zero_a_n), .adr_a(adr_a), .din_a(din_a), .dout_a(dout_a), .den_a(den_a),
        .clk_b(clk), .rst_b_n(rst_n), .pipe_b(pipe_b), .ceN_b_n(ceN_b_n), .ce_b(ce_b),
        .rw_b(rw_b), .oe_b_n(oe_b_n), .load_b_n(load_b_n), .step_b_n(step_b_n),
        .zero_b_n(zero_b_n), .adr_b(adr_b), .din_b(din_b), .dout_b(dout_b), .den_b(den_b)
    );

    typedef struct {
        logic          ceN_n, ce, rw, load_n, step_n, zero_n;
        logic [AW-1:0] adr;
        logic [DW-1:0] din;
    } cmd_t;

    typedef struct {
        int            t;
        logic          en;
        logic [DW-1:0] d;
        string         req;
    } item_t;

    item_t         qa[$];
    item_t         qb[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    int            cyc = 0;
    bit            mon_on = 0;
    bit            fin = 0;
    int            lat [2];
    logic [AW-1:0] ctr_m [2];
    logic [DW-1:0] mem_m [1 << AW];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic cmd_t c_nop();
        cmd_t c;
        c.ceN_n = 1'b1; c.ce = 1'b1; c.rw = 1'b1;
        c.load_n = 1'b1; c.step_n = 1'b1; c.zero_n = 1'b1;
        c.adr = '0; c.din = '0;
        return c;
    endfunction

    function automatic cmd_t c_rd(input logic [AW-1:0] a);
        cmd_t c = c_nop();
        c.ceN_n = 1'b0; c.load_n = 1'b0; c.adr = a;
        return c;
    endfunction

    function automatic cmd_t c_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_t c = c_rd(a);
        c.rw = 1'b0; c.din = d;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!fin) begin
            fin = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic put(input int p, input cmd_t c);
        if (p == 0) begin
            ceN_a_n = c.ceN_n; ce_a = c.ce; rw_a = c.rw; load_a_n = c.load_n;
            step_a_n = c.step_n; zero_a_n = c.zero_n; adr_a = c.adr; din_a = c.din;
        end else begin
            ceN_b_n = c.ceN_n; ce_b = c.ce; rw_b = c.rw; load_b_n = c.load_n;
            step_b_n = c.step_n; zero_b_n = c.zero_n; adr_b = c.adr; din_b = c.din;
        end
    endtask

    // driver: applies one cycle on both ports and pushes what each output must show
    task automatic go(input cmd_t ca, input cmd_t cb, input string req);
        cmd_t          cm [2];
        logic          rd [2];
        logic          wr [2];
        logic [DW-1:0] rv [2];
        item_t         it;
        cm[0] = ca;
        cm[1] = cb;
        @(negedge clk);
        put(0, ca);
        put(1, cb);
        for (int p = 0; p < 2; p++) begin
            if (!cm[p].zero_n)      ctr_m[p] = '0;
            else if (!cm[p].load_n) ctr_m[p] = cm[p].adr;
            else if (!cm[p].step_n) ctr_m[p] = ctr_m[p] + 1'b1;
            rd[p] = !cm[p].ceN_n && cm[p].ce && cm[p].rw;
            wr[p] = !cm[p].ceN_n && cm[p].ce && !cm[p].rw;
            rv[p] = rd[p] ? mem_m[ctr_m[p]] : '0;
        end
        for (int p = 0; p < 2; p++) begin
            if (wr[p]) mem_m[ctr_m[p]] = cm[p].din;
        end
        for (int p = 0; p < 2; p++) begin
            it.t = cyc + 1 + lat[p];
            it.en = rd[p];
            it.d = rv[p];
            it.req = req;
            if (p == 0) qa.push_back(it);
            else qb.push_back(it);
        end
    endtask

    task automatic cmp_port(input int p, input logic en, input logic [DW-1:0] d);
        item_t it;
        bit    got = 0;
        if (p == 0) begin
            if (qa.size() != 0 && qa[0].t == cyc) begin it = qa.pop_front(); got = 1; end
        end else begin
            if (qb.size() != 0 && qb[0].t == cyc) begin it = qb.pop_front(); got = 1; end
        end
        if (got) begin
            chk(en === it.en, it.req, $sformatf("port%0d den", p), int'(en), int'(it.en));
            chk(d === it.d, it.req, $sformatf("port%0d dout", p), int'(d), int'(it.d));
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            cmp_port(0, den_a, dout_a);
            cmp_port(1, den_b, dout_b);
        end
    end

    task automatic drain();
        @(negedge clk);
        put(0, c_nop());
        put(1, c_nop());
        repeat (4) @(negedge clk);
        chk(qa.size() == 0 && qb.size() == 0, "R3,R4", "pending items",
            qa.size() + qb.size(), 0);
    endtask

    task automatic do_reset(input bit pa, input bit pb);
        @(negedge clk);
        mon_on = 0;
        put(0, c_nop());
        put(1, c_nop());
        rst_n = 1'b0;
        pipe_a = pa;
        pipe_b = pb;
        repeat (2) @(negedge clk);
        qa.delete();
        qb.delete();
        lat[0] = pa ? 2 : 1;
        lat[1] = pb ? 2 : 1;
        ctr_m[0] = '0;
        ctr_m[1] = '0;
        chk(den_a === 1'b0 && dout_a === '0, "R5", "reset port0 den/dout", int'(den_a), 0);
        chk(den_b === 1'b0 && dout_b === '0, "R10", "reset port1 den/dout", int'(den_b), 0);
        rst_n = 1'b1;
        mon_on = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL all watchdog actual=running expected=finished");
        wrap_up();
    end

    initial begin
        cmd_t c;
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        rst_n = 1'b0;
        oe_a_n = 1'b0;
        oe_b_n = 1'b0;
        pipe_a = 1'b0;
        pipe_b = 1'b0;
        put(0, c_nop());
        put(1, c_nop());

        // phase 1: A flow-through, B pipelined
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) go(c_wr(AW'(i), DW'(i * 53 + 17)), c_nop(), "R1");
        for (int i = 0; i < 8; i++) go(c_nop(), c_rd(AW'(i)), "R4,R9");
        for (int i = 0; i < 8; i++) go(c_rd(AW'(7 - i)), c_nop(), "R3");

        // deselected writes leave memory alone
        c = c_wr(AW'(3), 9'h0AA); c.ceN_n = 1'b1;
        go(c, c_nop(), "R2");
        c.ceN_n = 1'b0; c.ce = 1'b0;
        go(c, c_nop(), "R2");
        c.rw = 1'b1;
        go(c, c_nop(), "R2");
        go(c_rd(AW'(3)), c_nop(), "R2");

        // both ports at once, then same-word collision
        go(c_wr(AW'(20), 9'h155), c_wr(AW'(21), 9'h0CC), "R9");
        go(c_rd(AW'(21)), c_rd(AW'(20)), "R9");
        go(c_wr(AW'(5), 9'h1E1), c_rd(AW'(5)), "R9");
        go(c_rd(AW'(5)), c_rd(AW'(5)), "R9");

        // read / write / nop / read on pipelined port
        go(c_nop(), c_rd(AW'(1)), "R5");
        go(c_nop(), c_wr(AW'(30), 9'h033), "R5");
        go(c_nop(), c_nop(), "R5");
        go(c_nop(), c_rd(AW'(30)), "R5");

        // address counter on A
        c = c_nop(); c.ceN_n = 1'b0; c.zero_n = 1'b0;
        go(c, c_nop(), "R7");
        c = c_nop(); c.ceN_n = 1'b0; c.step_n = 1'b0;
        go(c, c_nop(), "R7");
        go(c, c_nop(), "R7");
        c = c_nop(); c.ceN_n = 1'b0;
        go(c, c_nop(), "R7");
        c = c_rd(AW'(7)); c.zero_n = 1'b0;
        go(c, c_nop(), "R7");
        c = c_nop(); c.step_n = 1'b0;
        go(c, c_nop(), "R7");
        c = c_nop(); c.ceN_n = 1'b0;
        go(c, c_nop(), "R7");
        go(c_wr(AW'((1 << AW) - 1), 9'h1A5), c_nop(), "R7");
        go(c_rd(AW'((1 << AW) - 1)), c_nop(), "R7");
        c = c_nop(); c.ceN_n = 1'b0; c.step_n = 1'b0;
        go(c, c_nop(), "R7");

        // mode pins change without reset: latency stays
        pipe_a = 1'b1;
        pipe_b = 1'b0;
        for (int i = 0; i < 4; i++) go(c_rd(AW'(i)), c_rd(AW'(i + 4)), "R8");
        drain();

        // output enable acts at once (A flow-through)
        @(negedge clk);
        put(0, c_rd(AW'(2)));
        ctr_m[0] = AW'(2);
        @(negedge clk);
        put(0, c_nop());
        @(negedge clk);
        #1;
        chk(den_a === 1'b1, "R3", "oe low den", int'(den_a), 1);
        chk(dout_a === mem_m[2], "R3", "oe low dout", int'(dout_a), int'(mem_m[2]));
        oe_a_n = 1'b1;
        #1;
        chk(den_a === 1'b0, "R6", "oe high den", int'(den_a), 0);
        chk(dout_a === '0, "R10", "oe high dout", int'(dout_a), 0);
        oe_a_n = 1'b0;
        #1;
        chk(den_a === 1'b1, "R6", "oe low again den", int'(den_a), 1);
        @(negedge clk);
        #1;
        chk(den_a === 1'b0, "R5", "after nop den", int'(den_a), 0);

        // phase 2: modes swapped by a new reset
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) go(c_rd(AW'(i)), c_rd(AW'(7 - i)), "R3,R4");
        go(c_wr(AW'(9), 9'h0F0), c_nop(), "R1");
        go(c_rd(AW'(9)), c_rd(AW'(9)), "R3,R4");
        go(c_nop(), c_wr(AW'(9), 9'h10F), "R9");
        go(c_rd(AW'(9)), c_wr(AW'(40), 9'h077), "R5");
        go(c_rd(AW'(40)), c_nop(), "R4");
        go(c_nop(), c_nop(), "R5");
        drain();
        wrap_up();
    end

endmodule